// File: doc/BRIEF.md
# Sixteen-Channel DMA Control and Status Registers

This block is the bus-facing register file of a multi-channel DMA controller. Software programs each channel through a small window of four words: a source address, a destination address and two control words. The block hands those values to the transfer engines as flat configuration buses. It also raises a one-cycle start or abort strobe whenever a write to the first control word calls for one. The engines report back with one-cycle completion and failure pulses. The block turns those pulses into live busy readback, a per-channel done status that software clears by writing ones, and one level interrupt.

Beside the channel windows sits a global area. It holds an interrupt unmask word, the done-status word, a configuration word and three read-only words. The configuration word carries a writable arbitration-mode bit, a fixed version code and a fixed code for the channel count. The three read-only words mirror the engines' request, acknowledge and finish lines. Reads are word aligned and return data one cycle after the read cycle.

Top module: `chdma_csr`

## Requirements
- R1: After reset every channel word, the unmask word (0x200) and the done word (0x204) read 0, `irq` is 0 and no strobe is active; the configuration word (0x220) reads 0x0000000C for the defaults (version 2 in bits 2:1, count code 1 in bits 4:3).
- R2: Channel n owns byte addresses n*0x10 to n*0x10+0xC: source at +0x0, destination at +0x4, control word 0 at +0x8 and control word 1 at +0xC. A write reaches only the addressed word of the addressed channel. Control word 1 keeps only bits 25:16 and 13:0 (write mask 0x03FF3FFF); control word 0 keeps all 32 bits.
- R3: A write to control word 0 of an idle channel (bit 1, enable, reads 0) stores the word. If bit 1 of the written value is 1, `ch_start[n]` is high for exactly the cycle after the write, and bit 1 then reads 1 until the transfer ends.
- R4: A pulse on `ch_cmpl[n]` clears bit 1 of control word 0 and leaves its other bits. It sets bit n of the done word only if bit 2 (done-interrupt enable) of that control word is 1.
- R5: Writing 0 to control word 0 of a busy channel pulses `ch_abort[n]` for the cycle after the write, returns the word to 0 and sets no done bit.
- R6: A non-zero write to control word 0 of a busy channel is ignored: the word is unchanged and no start strobe appears.
- R7: Writing to the done word clears each bit written as 1 and keeps each bit written as 0. A completion that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R8: The unmask word holds one bit per channel, and `irq` is 1 exactly when some bit is 1 in both the done word and the unmask word.
- R9: A pulse on `ch_fail[n]` sets bit 1 of control word 1, clears bit 1 of control word 0 and sets no done bit.
- R10: Bit 0 of the configuration word is read/write and drives `arb_rr`. Bits 2:1 (version) and 4:3 (log2 of channel count over 8) ignore writes.
- R11: Words 0x2A0, 0x2A4 and 0x2A8 read `ch_req`, `ch_ack` and `ch_fin` with bit n for channel n. Unmapped addresses read 0. Read data appears on `bus_rdata` in the cycle after the read cycle.
- R12: `ch_src_addr`, `ch_dst_addr`, `ch_ctrl0` and `ch_ctrl1` carry channel n's stored words in bits n*32+31 to n*32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| ch_start | output | NCH (16) | One-cycle start strobe per channel |
| ch_abort | output | NCH (16) | One-cycle abort strobe per channel |
| ch_src_addr | output | NCH*32 | Source address of every channel |
| ch_dst_addr | output | NCH*32 | Destination address of every channel |
| ch_ctrl0 | output | NCH*32 | Control word 0 of every channel |
| ch_ctrl1 | output | NCH*32 | Control word 1 of every channel |
| ch_cmpl | input | NCH (16) | Completion pulse per channel |
| ch_fail | input | NCH (16) | Failure pulse per channel |
| ch_req | input | NCH (16) | Request line levels |
| ch_ack | input | NCH (16) | Acknowledge line levels |
| ch_fin | input | NCH (16) | Finish line levels |
| arb_rr | output | 1 | Round-robin arbitration select |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the cycle in which a completion and a done-clear write land together. A design that lets the clear win drops that interrupt for good. It issues a non-zero control write to a busy channel; a design that accepts it would restart a running engine or corrupt its length. It completes a channel whose done-interrupt enable is 0; a design that ignores that bit raises a spurious done. It also aborts a busy channel and checks that the register returns to 0 with no done bit, and it writes all ones to control word 1 and the configuration word to prove that the undefined and read-only bits stay put.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

  localparam int WORD = 32;

  // word slot inside a channel window (address bits 3:2)
  localparam logic [1:0] SLOT_SRC = 2'd0;
  localparam logic [1:0] SLOT_DST = 2'd1;
  localparam logic [1:0] SLOT_C0  = 2'd2;
  localparam logic [1:0] SLOT_C1  = 2'd3;

  // global word offsets
  localparam logic [11:0] GOFF_UNMASK = 12'h200;
  localparam logic [11:0] GOFF_DONE   = 12'h204;
  localparam logic [11:0] GOFF_CFG    = 12'h220;
  localparam logic [11:0] GOFF_REQ    = 12'h2A0;
  localparam logic [11:0] GOFF_ACK    = 12'h2A4;
  localparam logic [11:0] GOFF_FIN    = 12'h2A8;

  // control word bit positions the block acts on
  localparam int C0_RUN   = 1;
  localparam int C0_IRQEN = 2;
  localparam int C1_ERR   = 1;
  localparam logic [WORD-1:0] C1_KEEP = 32'h03FF_3FFF;

  typedef enum logic [2:0] {
    GSEL_NONE,
    GSEL_UNMASK,
    GSEL_DONE,
    GSEL_CFG,
    GSEL_REQ,
    GSEL_ACK,
    GSEL_FIN
  } gsel_e;

  function automatic logic [1:0] count_code(input int nch);
    return 2'($clog2(nch / 8));
  endfunction

  function automatic logic [WORD-1:0] cfg_pack(input logic rr,
                                               input logic [1:0] ver,
                                               input logic [1:0] code);
    return {27'd0, code, ver, rr};
  endfunction

  // next value of done status: clear written ones, then apply new sets
  function automatic logic [WORD-1:0] done_next(input logic [WORD-1:0] cur,
                                                input logic [WORD-1:0] clr,
                                                input logic [WORD-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/chdma_addr_dec.sv
module chdma_addr_dec
  import chdma_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  output logic [NCH-1:0]          ch_hit,
  output logic                    in_ch,
  output logic [$clog2(NCH)-1:0]  ch_idx,
  output logic [1:0]              slot,
  output gsel_e                   gsel
);

  localparam int IDX_W = $clog2(NCH);
  localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NCH * 16);

  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_ch   = aligned && (addr < CH_SPAN);
  assign ch_idx  = addr[4 +: IDX_W];
  assign slot    = addr[3:2];

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign ch_hit[i] = in_ch && (int'(addr[ADDR_W-1:4]) == i);
  end

  always_comb begin
    gsel = GSEL_NONE;
    if (aligned) begin
      if      (addr == ADDR_W'(GOFF_UNMASK)) gsel = GSEL_UNMASK;
      else if (addr == ADDR_W'(GOFF_DONE))   gsel = GSEL_DONE;
      else if (addr == ADDR_W'(GOFF_CFG))    gsel = GSEL_CFG;
      else if (addr == ADDR_W'(GOFF_REQ))    gsel = GSEL_REQ;
      else if (addr == ADDR_W'(GOFF_ACK))    gsel = GSEL_ACK;
      else if (addr == ADDR_W'(GOFF_FIN))    gsel = GSEL_FIN;
    end
  end

  // R2: at most one channel window claims an address, never with a global
  assert_one_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit) && !((|ch_hit) && (gsel != GSEL_NONE)));

endmodule

// File: rtl/chdma_chan.sv
module chdma_chan
  import chdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_src,
  input  logic            wr_dst,
  input  logic            wr_c0,
  input  logic            wr_c1,
  input  logic [WORD-1:0] wdata,
  input  logic            cmpl_i,
  input  logic            fail_i,
  output logic [WORD-1:0] src_o,
  output logic [WORD-1:0] dst_o,
  output logic [WORD-1:0] c0_o,
  output logic [WORD-1:0] c1_o,
  output logic            start_o,
  output logic            abort_o,
  output logic            done_set_o
);

  logic [WORD-1:0] src_q, dst_q, c0_q, c1_q;
  logic [WORD-1:0] c0_d, c1_d;
  logic            busy;
  logic            ev_start, ev_abort, ev_stop;

  assign busy     = c0_q[C0_RUN];
  assign ev_stop  = cmpl_i || fail_i;
  assign ev_start = wr_c0 && !busy && wdata[C0_RUN];
  assign ev_abort = wr_c0 && busy && (wdata == '0);

  always_comb begin
    c0_d = c0_q;
    if (ev_stop) c0_d[C0_RUN] = 1'b0;
    if (wr_c0 && !busy) c0_d = wdata;
    else if (ev_abort)  c0_d = '0;
  end

  always_comb begin
    c1_d = c1_q;
    if (wr_c1)  c1_d = wdata & C1_KEEP;
    if (fail_i) c1_d[C1_ERR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      c0_q    <= '0;
      c1_q    <= '0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      if (wr_src) src_q <= wdata;
      if (wr_dst) dst_q <= wdata;
      c0_q    <= c0_d;
      c1_q    <= c1_d;
      start_o <= ev_start;
      abort_o <= ev_abort;
    end
  end

  assign done_set_o = cmpl_i && c0_q[C0_IRQEN];
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign c0_o  = c0_q;
  assign c1_o  = c1_q;

  // R3: a start strobe always coincides with a running channel
  assert_start_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> c0_q[C0_RUN]);

  // R4: completion of a running channel leaves it idle
  assert_cmpl_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && c0_q[C0_RUN]) |=> !c0_q[C0_RUN]);

  // R5: an abort strobe comes with a cleared control word
  assert_abort_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (c0_q == '0));

  // R6: non-zero write while running leaves control word 0 untouched
  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c0 && c0_q[C0_RUN] && (wdata != '0) && !cmpl_i && !fail_i)
      |=> ($stable(c0_q) && !start_o));

endmodule

// File: rtl/chdma_glob.sv
module chdma_glob
  import chdma_pkg::*;
#(
  parameter int           NCH     = 16,
  parameter logic [1:0]   VERSION = 2'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_unmask,
  input  logic            wr_done,
  input  logic            wr_cfg,
  input  logic [NCH-1:0]  wdata,
  input  logic [NCH-1:0]  done_set,
  output logic [NCH-1:0]  unmask_o,
  output logic [NCH-1:0]  done_o,
  output logic [WORD-1:0] cfg_o,
  output logic            arb_rr_o,
  output logic            irq_o
);

  localparam logic [1:0] CODE = count_code(NCH);

  logic [NCH-1:0]  unmask_q, done_q;
  logic            rr_q;
  logic [WORD-1:0] done_w;

  assign done_w = done_next(WORD'(done_q),
                            wr_done ? WORD'(wdata) : '0,
                            WORD'(done_set));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unmask_q <= '0;
      done_q   <= '0;
      rr_q     <= 1'b0;
    end else begin
      if (wr_unmask) unmask_q <= wdata;
      if (wr_cfg)    rr_q     <= wdata[0];
      done_q <= done_w[NCH-1:0];
    end
  end

  assign unmask_o = unmask_q;
  assign done_o   = done_q;
  assign arb_rr_o = rr_q;
  assign cfg_o    = cfg_pack(rr_q, VERSION, CODE);
  assign irq_o    = |(done_q & unmask_q);

  // R4: an accepted completion is recorded in the done word
  assert_done_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_set) |=> ((done_q & $past(done_set)) == $past(done_set)));

  // R7: bits written as one without a concurrent set are cleared
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> ((done_q & $past(wdata & ~done_set)) == '0));

  // R8: the interrupt falls once no unmasked done bit remains
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_q & unmask_q) == '0) |-> !irq_o);

endmodule

// File: rtl/chdma_csr.sv
module chdma_csr
  import chdma_pkg::*;
#(
  parameter int         NCH     = 16,
  parameter int         ADDR_W  = 12,
  parameter logic [1:0] VERSION = 2'd2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_cs,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NCH-1:0]      ch_start,
  output logic [NCH-1:0]      ch_abort,
  output logic [NCH*32-1:0]   ch_src_addr,
  output logic [NCH*32-1:0]   ch_dst_addr,
  output logic [NCH*32-1:0]   ch_ctrl0,
  output logic [NCH*32-1:0]   ch_ctrl1,
  input  logic [NCH-1:0]      ch_cmpl,
  input  logic [NCH-1:0]      ch_fail,
  input  logic [NCH-1:0]      ch_req,
  input  logic [NCH-1:0]      ch_ack,
  input  logic [NCH-1:0]      ch_fin,
  output logic                arb_rr,
  output logic                irq
);

  localparam int IDX_W = $clog2(NCH);

  logic [NCH-1:0]   ch_hit;
  logic             in_ch;
  logic [IDX_W-1:0] ch_idx;
  logic [1:0]       slot;
  gsel_e            gsel;
  logic             wr_cyc, rd_cyc;

  logic [WORD-1:0]  src_a [NCH];
  logic [WORD-1:0]  dst_a [NCH];
  logic [WORD-1:0]  c0_a  [NCH];
  logic [WORD-1:0]  c1_a  [NCH];
  logic [NCH-1:0]   done_set;
  logic [NCH-1:0]   unmask_q, done_q;
  logic [WORD-1:0]  cfg_w;
  logic [WORD-1:0]  rd_mux, rdata_q;

  assign wr_cyc = bus_cs && bus_we;
  assign rd_cyc = bus_cs && !bus_we;

  chdma_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .ch_hit (ch_hit),
    .in_ch  (in_ch),
    .ch_idx (ch_idx),
    .slot   (slot),
    .gsel   (gsel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = wr_cyc && ch_hit[i];

    chdma_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_src     (sel && (slot == SLOT_SRC)),
      .wr_dst     (sel && (slot == SLOT_DST)),
      .wr_c0      (sel && (slot == SLOT_C0)),
      .wr_c1      (sel && (slot == SLOT_C1)),
      .wdata      (bus_wdata),
      .cmpl_i     (ch_cmpl[i]),
      .fail_i     (ch_fail[i]),
      .src_o      (src_a[i]),
      .dst_o      (dst_a[i]),
      .c0_o       (c0_a[i]),
      .c1_o       (c1_a[i]),
      .start_o    (ch_start[i]),
      .abort_o    (ch_abort[i]),
      .done_set_o (done_set[i])
    );

    assign ch_src_addr[i*32 +: 32] = src_a[i];
    assign ch_dst_addr[i*32 +: 32] = dst_a[i];
    assign ch_ctrl0[i*32 +: 32]    = c0_a[i];
    assign ch_ctrl1[i*32 +: 32]    = c1_a[i];
  end

  chdma_glob #(.NCH(NCH), .VERSION(VERSION)) u_glob (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_unmask (wr_cyc && (gsel == GSEL_UNMASK)),
    .wr_done   (wr_cyc && (gsel == GSEL_DONE)),
    .wr_cfg    (wr_cyc && (gsel == GSEL_CFG)),
    .wdata     (bus_wdata[NCH-1:0]),
    .done_set  (done_set),
    .unmask_o  (unmask_q),
    .done_o    (done_q),
    .cfg_o     (cfg_w),
    .arb_rr_o  (arb_rr),
    .irq_o     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (in_ch) begin
      case (slot)
        SLOT_SRC: rd_mux = src_a[ch_idx];
        SLOT_DST: rd_mux = dst_a[ch_idx];
        SLOT_C0:  rd_mux = c0_a[ch_idx];
        default:  rd_mux = c1_a[ch_idx];
      endcase
    end else begin
      case (gsel)
        GSEL_UNMASK: rd_mux = WORD'(unmask_q);
        GSEL_DONE:   rd_mux = WORD'(done_q);
        GSEL_CFG:    rd_mux = cfg_w;
        GSEL_REQ:    rd_mux = WORD'(ch_req);
        GSEL_ACK:    rd_mux = WORD'(ch_ack);
        GSEL_FIN:    rd_mux = WORD'(ch_fin);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cyc) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R3/R5: a channel never starts and aborts in the same cycle
  assert_no_start_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start & ch_abort) == '0);

endmodule

// File: tb/chdma_csr_tb.sv
module chdma_csr_tb;

  localparam int NCH = 16;
  localparam int AW  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_cs = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  ch_start, ch_abort;
  logic [NCH*32-1:0] ch_src_addr, ch_dst_addr, ch_ctrl0, ch_ctrl1;
  logic [NCH-1:0]  ch_cmpl = '0, ch_fail = '0;
  logic [NCH-1:0]  ch_req = '0, ch_ack = '0, ch_fin = '0;
  logic            arb_rr, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  chdma_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_start(ch_start), .ch_abort(ch_abort),
    .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr),
    .ch_ctrl0(ch_ctrl0), .ch_ctrl1(ch_ctrl1),
    .ch_cmpl(ch_cmpl), .ch_fail(ch_fail),
    .ch_req(ch_req), .ch_ack(ch_ack), .ch_fin(ch_fin),
    .arb_rr(arb_rr), .irq(irq)
  );

  function automatic logic [AW-1:0] cw(input int ch, input int slot);
    return AW'(ch * 16 + slot * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(input bit is_fail, input int ch);
    @(negedge clk);
    if (is_fail) ch_fail[ch] = 1'b1; else ch_cmpl[ch] = 1'b1;
    @(negedge clk);
    ch_fail = '0; ch_cmpl = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ch0 src", cw(0, 0), 32'h0);
    rd_chk("R1 ch15 ctrl0", cw(15, 2), 32'h0);
    rd_chk("R1 ch15 ctrl1", cw(15, 3), 32'h0);
    rd_chk("R1 unmask", 12'h200, 32'h0);
    rd_chk("R1 done", 12'h204, 32'h0);
    rd_chk("R1 cfg", 12'h220, 32'h0000_000C);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 strobes", 32'({ch_start, ch_abort}), 32'h0);
  endtask

  task automatic t_window();
    wr(cw(3, 0), 32'hA000_0030);
    wr(cw(3, 1), 32'hB000_0034);
    wr(cw(15, 0), 32'hC000_00F0);
    wr(cw(3, 3), 32'hFFFF_FFFF);
    rd_chk("R2 ch3 src", cw(3, 0), 32'hA000_0030);
    rd_chk("R2 ch3 dst", cw(3, 1), 32'hB000_0034);
    rd_chk("R2 ch15 src", cw(15, 0), 32'hC000_00F0);
    rd_chk("R2 ch3 ctrl1 mask", cw(3, 3), 32'h03FF_3FFF);
    rd_chk("R2 ch4 src untouched", cw(4, 0), 32'h0);
    rd_chk("R2 ch2 ctrl1 untouched", cw(2, 3), 32'h0);
    check("R12 ch3 src bus", ch_src_addr[3*32 +: 32], 32'hA000_0030);
    check("R12 ch3 dst bus", ch_dst_addr[3*32 +: 32], 32'hB000_0034);
    check("R12 ch3 ctrl1 bus", ch_ctrl1[3*32 +: 32], 32'h03FF_3FFF);
  endtask

  task automatic t_start_ignore_cmpl();
    // channel 5: length 0x40, done-irq enable (bit 2), enable (bit 1)
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = cw(5, 2); bus_wdata = 32'h0040_0006;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
    check("R3 start pulse", 32'(ch_start), 32'h0000_0020);
    @(negedge clk);
    check("R3 start one cycle", 32'(ch_start), 32'h0);
    rd_chk("R3 ctrl0 busy", cw(5, 2), 32'h0040_0006);
    check("R12 ctrl0 bus", ch_ctrl0[5*32 +: 32], 32'h0040_0006);
    // R6: non-zero write while busy
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = cw(5, 2); bus_wdata = 32'h1234_0006;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
    check("R6 no restart", 32'(ch_start), 32'h0);
    rd_chk("R6 ctrl0 kept", cw(5, 2), 32'h0040_0006);
    // R4: completion
    pulse(1'b0, 5);
    rd_chk("R4 enable cleared", cw(5, 2), 32'h0040_0004);
    rd_chk("R4 done set", 12'h204, 32'h0000_0020);
    check("R8 masked irq", 32'(irq), 32'h0);
    wr(12'h200, 32'h0000_0020);
    rd_chk("R8 unmask readback", 12'h200, 32'h0000_0020);
    check("R8 irq on", 32'(irq), 32'h1);
    wr(12'h204, 32'h0000_0010);
    rd_chk("R7 zero keeps", 12'h204, 32'h0000_0020);
    wr(12'h204, 32'h0000_0020);
    rd_chk("R7 one clears", 12'h204, 32'h0);
    check("R8 irq off", 32'(irq), 32'h0);
  endtask

  task automatic t_no_irq_enable();
    wr(cw(6, 2), 32'h0000_0002);
    pulse(1'b0, 6);
    rd_chk("R4 no ie ctrl0", cw(6, 2), 32'h0);
    rd_chk("R4 no ie done", 12'h204, 32'h0);
  endtask

  task automatic t_abort();
    wr(cw(7, 2), 32'h0010_0006);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = cw(7, 2); bus_wdata = 32'h0;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
    check("R5 abort pulse", 32'(ch_abort), 32'h0000_0080);
    @(negedge clk);
    check("R5 abort one cycle", 32'(ch_abort), 32'h0);
    rd_chk("R5 ctrl0 zero", cw(7, 2), 32'h0);
    rd_chk("R5 no done", 12'h204, 32'h0);
  endtask

  task automatic t_fail();
    wr(cw(8, 2), 32'h0000_0006);
    pulse(1'b1, 8);
    rd_chk("R9 fail flag", cw(8, 3), 32'h0000_0002);
    rd_chk("R9 enable cleared", cw(8, 2), 32'h0000_0004);
    rd_chk("R9 no done", 12'h204, 32'h0);
  endtask

  task automatic t_collide();
    wr(cw(9, 2), 32'h0000_0006);
    @(negedge clk);
    ch_cmpl[9] = 1'b1;
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 12'h204; bus_wdata = 32'h0000_0200;
    @(negedge clk);
    ch_cmpl = '0; bus_cs = 1'b0; bus_we = 1'b0;
    rd_chk("R7 set beats clear", 12'h204, 32'h0000_0200);
    wr(12'h204, 32'h0000_0200);
    rd_chk("R7 cleared after", 12'h204, 32'h0);
  endtask

  task automatic t_cfg();
    wr(12'h220, 32'hFFFF_FFFF);
    rd_chk("R10 cfg after ones", 12'h220, 32'h0000_000D);
    check("R10 arb_rr on", 32'(arb_rr), 32'h1);
    wr(12'h220, 32'h0);
    rd_chk("R10 cfg after zero", 12'h220, 32'h0000_000C);
    check("R10 arb_rr off", 32'(arb_rr), 32'h0);
  endtask

  task automatic t_status();
    @(negedge clk);
    ch_req = 16'hA5A5; ch_ack = 16'h0F0F; ch_fin = 16'h8001;
    rd_chk("R11 req", 12'h2A0, 32'h0000_A5A5);
    rd_chk("R11 ack", 12'h2A4, 32'h0000_0F0F);
    rd_chk("R11 fin", 12'h2A8, 32'h0000_8001);
    rd_chk("R11 gap read", 12'h100, 32'h0);
    rd_chk("R11 unmapped high", 12'h300, 32'h0);
    wr(12'h2A0, 32'hFFFF_FFFF);
    rd_chk("R11 req read-only", 12'h2A0, 32'h0000_A5A5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_start_ignore_cmpl();
    t_no_irq_enable();
    t_abort();
    t_fail();
    t_collide();
    t_cfg();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule